// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block sends a stream of stereo PCM sample pairs over a three-wire serial audio link, acting as the clock master. From the system clock it makes a serial bit clock and a frame clock, and it shifts each sample out most significant bit first on a data wire. Samples arrive as a parallel left/right pair through a valid/ready handshake. The block accepts one pair per frame, at the frame boundary.

Five framings share one serializer: left-justified, right-justified, I2S, and two short-sync framings (sync pulse one bit before the data, or on the first data bit). Format, word length and bit clocks per frame are set on static input ports, which are held constant while the block is out of reset. Illegal combinations are flagged and produce no data. If no pair is offered at a frame boundary, the previous pair is sent again and a one-cycle underrun pulse is raised.

Top module: `aud_ser_tx`

## Requirements
- R1: `cfg_rate` sets the bit clocks per frame: 0 gives 64, 1 gives 32, 2 gives 16, 3 gives 256 with the bit clock equal to the system clock. Every frame lasts 256 system clock cycles, so the bit clock is the system clock divided by 4, 8 or 16 for codes 0 to 2.
- R2: `ser_dat` and `frm_clk` change only on falling edges of `ser_clk` and are stable across every rising edge.
- R3: `cfg_wlen` gives the word length: 0 gives 16, 1 gives 20, 2 gives 24, 3 gives 32 bits. The sample sits in the low bits of each 32-bit input word and is sent MSB first.
- R4: Left-justified (`cfg_fmt`=0): `frm_clk` is high for the first half of the frame (left channel) and low for the second half. Each word starts at the first slot of its half.
- R5: Right-justified (`cfg_fmt`=1): the frame clock is the same as in R4. Each word ends with its LSB in the last slot of its half.
- R6: I2S (`cfg_fmt`=2): `frm_clk` is low for the first half (left) and high for the second half. Each word starts one slot after its half begins, and the right word's LSB may spill into slot 0 of the next frame.
- R7: Short-sync formats (`cfg_fmt`=3 with delay, 4 without): `frm_clk` is high only in slot 0. The left word starts at slot 1 (code 3) or slot 0 (code 4), and the right word follows directly. With code 3 the right word's last bit may spill into slot 0 of the next frame.
- R8: Every slot that carries no sample bit drives `ser_dat` low.
- R9: `smp_ready` is high for exactly one system cycle per frame, at the edge that starts slot 0. A pair offered there is sent in that frame. The first slot after reset is slot 0.
- R10: If `smp_valid` is low when `smp_ready` is high, `underrun` pulses in that cycle and the previous pair (zeros after reset) is sent again.
- R11: `cfg_err` is high for a `cfg_fmt` above 4, for right-justified with 32-bit words, or when the frame has fewer bit slots than twice the word length. While it is high, `ser_dat` stays low, `smp_ready` stays low and `underrun` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 3 | Framing format code |
| cfg_wlen | input | 2 | Word length code |
| cfg_rate | input | 2 | Bit clocks per frame code |
| smp_valid | input | 1 | A sample pair is offered |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| smp_ready | output | 1 | Pair taken at this edge (frame start) |
| ser_clk | output | 1 | Serial bit clock |
| frm_clk | output | 1 | Frame / channel clock |
| ser_dat | output | 1 | Serial data |
| cfg_err | output | 1 | Illegal configuration |
| underrun | output | 1 | No pair available at frame start |

## Verification
The main function is tried with random sample pairs across all five framings. The settings are chosen so that each placement rule is separated from the others: right-justified at 24 bits in a 64-slot frame (leading padding), I2S and delayed short-sync with the frame exactly twice the word length (spill into the next frame), and the undelayed short-sync at 24 bits. Each framing is also run at a different rate code, including the system-clock pass-through, and the spacing between frame starts separates a wrong divider from a wrong slot count. Each run withholds pairs for the last frames, so the repeat and underrun behaviour is seen after real data. Three illegal settings check that the block stays silent.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SMP_W   = 32;
  localparam int IDX_W   = $clog2(SMP_W);
  localparam int MAX_BPF = 256;
  localparam int SLOT_W  = $clog2(MAX_BPF);

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  function automatic int bits_per_frame(input logic [1:0] rate);
    case (rate)
      2'd0:    return 64;
      2'd1:    return 32;
      2'd2:    return 16;
      default: return MAX_BPF;
    endcase
  endfunction

  function automatic int word_len(input logic [1:0] wl);
    case (wl)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic cfg_illegal(input logic [2:0] fmt, input logic [1:0] wl,
                                       input logic [1:0] rate);
    int w;
    w = word_len(wl);
    return (fmt > 3'd4) || (fmt == FMT_RJ && w == 32) || (bits_per_frame(rate) < 2 * w);
  endfunction

  function automatic logic frame_level(input logic [2:0] fmt, input logic [1:0] rate,
                                       input logic [SLOT_W-1:0] slot);
    int s, h;
    s = int'(slot);
    h = bits_per_frame(rate) / 2;
    if (fmt == FMT_DSPA || fmt == FMT_DSPB) return (s == 0);
    if (fmt == FMT_I2S) return (s >= h);
    return (s < h);
  endfunction

  function automatic logic slot_data(input logic [2:0] fmt, input logic [1:0] wl,
                                     input logic [1:0] rate, input logic [SLOT_W-1:0] slot,
                                     input logic [SMP_W-1:0] left, input logic [SMP_W-1:0] right,
                                     input logic [SMP_W-1:0] prev_right);
    int bpf, h, w, s, q, p, idx;
    logic dsp, dly, hit, rsel;
    logic [SMP_W-1:0] word;
    bpf  = bits_per_frame(rate);
    h    = bpf / 2;
    w    = word_len(wl);
    s    = int'(slot);
    dsp  = (fmt == FMT_DSPA) || (fmt == FMT_DSPB);
    dly  = (fmt == FMT_I2S) || (fmt == FMT_DSPA);
    q    = (dly && s == 0) ? bpf - 1 : (dly ? s - 1 : s);
    hit  = 1'b0;
    rsel = 1'b0;
    idx  = 0;
    if (dsp) begin
      if (q < w) begin
        hit = 1'b1; idx = w - 1 - q;
      end else if (q < 2 * w) begin
        hit = 1'b1; rsel = 1'b1; idx = 2 * w - 1 - q;
      end
    end else begin
      rsel = (q >= h);
      p    = rsel ? q - h : q;
      if (fmt == FMT_RJ) begin
        hit = (p >= h - w); idx = h - 1 - p;
      end else begin
        hit = (p < w); idx = w - 1 - p;
      end
    end
    // a delayed word spilling into slot 0 belongs to the previous pair
    word = rsel ? ((dly && s == 0) ? prev_right : right) : left;
    return hit ? word[IDX_W'(idx)] : 1'b0;
  endfunction
endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen
  import aud_tx_pkg::*;
#(
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate,
  output logic       ser_clk,
  output logic       fall_evt,
  output logic       rise_evt
);
  localparam int CW = $clog2(BASE_HALF * 4);

  logic [CW-1:0] cnt;
  logic          sclk_q;
  logic          pass;
  logic [CW-1:0] half_m1;
  logic          flip;

  assign pass    = (rate == 2'd3);
  assign half_m1 = CW'((BASE_HALF << rate) - 1);
  assign flip    = !pass && (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (pass) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (flip) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fall_evt = pass || (flip && sclk_q);
  assign rise_evt = flip && !sclk_q;
  // pass-through: inverted so that register updates land on falling bit-clock edges
  assign ser_clk  = pass ? ~clk : sclk_q;

  AST_CLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && $past(!pass) && $changed(sclk_q)) |-> $past(cnt) == half_m1); // R1
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate,
  input  logic              fall_evt,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              load_evt
);
  logic [SLOT_W:0] bpf_lim;
  logic            wrap;

  assign bpf_lim  = (SLOT_W + 1)'(bits_per_frame(rate));
  assign wrap     = ({1'b0, slot} >= bpf_lim - 1'b1);
  assign slot_nxt = wrap ? '0 : slot + 1'b1;
  assign load_evt = fall_evt && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slot <= '1;
    else if (fall_evt) slot <= slot_nxt;
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> ({1'b0, slot} < bpf_lim)); // R1
endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
  import aud_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt,
  input  logic [1:0]        wl,
  input  logic [1:0]        rate,
  input  logic              err,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              load_evt,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] slot_nxt,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_left,
  input  logic [SMP_W-1:0]  smp_right,
  output logic              smp_ready,
  output logic              underrun,
  output logic              ser_dat,
  output logic              frm_clk
);
  logic [SMP_W-1:0] held_l, held_r, prev_r;
  logic [SMP_W-1:0] nxt_l, nxt_r, nxt_prev;
  logic             take, dat_q, frm_q;

  assign smp_ready = load_evt && !err;
  assign take      = smp_ready && smp_valid;
  assign underrun  = smp_ready && !smp_valid;

  always_comb begin
    nxt_l    = take ? smp_left : held_l;
    nxt_r    = take ? smp_right : held_r;
    nxt_prev = load_evt ? held_r : prev_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_l <= '0;
      held_r <= '0;
      prev_r <= '0;
      dat_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else if (fall_evt) begin
      held_l <= nxt_l;
      held_r <= nxt_r;
      prev_r <= nxt_prev;
      frm_q  <= frame_level(fmt, rate, slot_nxt);
      dat_q  <= err ? 1'b0 : slot_data(fmt, wl, rate, slot_nxt, nxt_l, nxt_r, nxt_prev);
    end
  end

  assign ser_dat = dat_q;
  assign frm_clk = frm_q;

  AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> $stable(dat_q) && $stable(frm_q)); // R2
  AST_SYNC_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    ((fmt == FMT_DSPA || fmt == FMT_DSPB) && !err && $rose(frm_q)) |-> slot == '0); // R7
  AST_READY_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> slot == '0); // R9
  AST_REPEAT_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> $stable(held_l) && $stable(held_r)); // R10
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !dat_q); // R11
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int BASE_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_fmt,
  input  logic [1:0]       cfg_wlen,
  input  logic [1:0]       cfg_rate,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             smp_ready,
  output logic             ser_clk,
  output logic             frm_clk,
  output logic             ser_dat,
  output logic             cfg_err,
  output logic             underrun
);
  logic              fall_evt, rise_evt, load_evt;
  logic [SLOT_W-1:0] slot, slot_nxt;

  assign cfg_err = cfg_illegal(cfg_fmt, cfg_wlen, cfg_rate);

  aud_tx_clkgen #(.BASE_HALF(BASE_HALF)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .rate(cfg_rate),
    .ser_clk(ser_clk), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  aud_tx_framer framer_i (
    .clk(clk), .rst_n(rst_n), .rate(cfg_rate), .fall_evt(fall_evt),
    .slot(slot), .slot_nxt(slot_nxt), .load_evt(load_evt)
  );

  aud_tx_serializer ser_i (
    .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt), .wl(cfg_wlen), .rate(cfg_rate),
    .err(cfg_err), .fall_evt(fall_evt), .rise_evt(rise_evt), .load_evt(load_evt),
    .slot(slot), .slot_nxt(slot_nxt), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .smp_ready(smp_ready), .underrun(underrun),
    .ser_dat(ser_dat), .frm_clk(frm_clk)
  );
endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0;
  logic [1:0]  cfg_wlen = 2'd0;
  logic [1:0]  cfg_rate = 2'd0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_left = '0, smp_right = '0;
  logic        smp_ready, ser_clk, frm_clk, ser_dat, cfg_err, underrun;

  int n_cmp = 0, n_bad = 0, ur_cnt = 0;
  logic [63:0] exp_q[$];
  logic exp_bits[512];
  logic carry[256];
  logic got_d[256], got_f[256];

  always #5 clk = ~clk;

  aud_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_rate(cfg_rate),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .smp_ready(smp_ready), .ser_clk(ser_clk), .frm_clk(frm_clk), .ser_dat(ser_dat),
    .cfg_err(cfg_err), .underrun(underrun)
  );

  always @(posedge clk) if (rst_n && underrun) ur_cnt = ur_cnt + 1;

  function automatic int tb_bpf(input logic [1:0] r);
    int t[4] = '{64, 32, 16, 256};
    return t[r];
  endfunction
  function automatic int tb_w(input logic [1:0] c);
    return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
  endfunction
  function automatic string fmt_tag(input logic [2:0] f);
    case (f)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int got, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  // expected layout: place each word at its start slot; bits past the frame carry over
  task automatic build_frame(input logic [31:0] l, input logic [31:0] r);
    int bpf = tb_bpf(cfg_rate), w = tb_w(cfg_wlen), h, sl, sr;
    h = bpf / 2;
    for (int s = 0; s < 512; s++) exp_bits[s] = (s < bpf) ? carry[s] : 1'b0;
    case (cfg_fmt)
      3'd0: begin sl = 0;     sr = h;       end
      3'd1: begin sl = h - w; sr = bpf - w; end
      3'd2: begin sl = 1;     sr = h + 1;   end
      3'd3: begin sl = 1;     sr = w + 1;   end
      default: begin sl = 0;  sr = w;       end
    endcase
    for (int i = 0; i < w; i++) begin
      exp_bits[sl + i] = l[w - 1 - i];
      exp_bits[sr + i] = r[w - 1 - i];
    end
    for (int s = 0; s < bpf; s++) carry[s] = exp_bits[s + bpf];
  endtask

  function automatic logic exp_frm(input int s);
    int h = tb_bpf(cfg_rate) / 2;
    case (cfg_fmt)
      3'd0, 3'd1: return s < h;
      3'd2:       return s >= h;
      default:    return s == 0;
    endcase
  endfunction

  task automatic driver(input int n);
    for (int i = 0; i < n; i++) begin
      smp_left  = $urandom;
      smp_right = $urandom;
      smp_valid = 1'b1;
      while (!smp_ready) @(negedge clk);
      exp_q.push_back({smp_left, smp_right});  // R9: taken at the coming edge
      @(posedge clk);
      #1;
    end
    smp_valid = 1'b0;
  endtask

  task automatic monitor(input int frames);
    int bpf = tb_bpf(cfg_rate);
    logic [63:0] cur = '0;
    longint tprev = 0, t0;
    int urlast = ur_cnt, bad_s;
    for (int s = 0; s < 256; s++) carry[s] = 1'b0;
    wait (rst_n);
    @(negedge ser_clk);
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < bpf; s++) begin
        @(posedge ser_clk);
        if (s == 0) begin
          t0 = longint'($time);
          if (f > 0) check(t0 - tprev == 2560, "R1", "frame period", int'(t0 - tprev), 2560);
          tprev = t0;
          if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            check(ur_cnt == urlast, "R10", "no underrun with data", ur_cnt, urlast);
          end else begin
            check(ur_cnt == urlast + 1, "R10", "underrun pulse", ur_cnt, urlast + 1);
          end
          urlast = ur_cnt;
        end
        got_d[s] = ser_dat;
        got_f[s] = frm_clk;
      end
      build_frame(cur[63:32], cur[31:0]);
      bad_s = -1;
      for (int s = 0; s < bpf; s++)
        if (bad_s < 0 && (got_d[s] !== exp_bits[s] || got_f[s] !== exp_frm(s))) bad_s = s;
      // R3 R8 and the format rule: whole frame, bit by bit
      if (bad_s < 0) check(1'b1, fmt_tag(cfg_fmt), "frame", 0, 0);
      else check(1'b0, fmt_tag(cfg_fmt), $sformatf("R3 R8 slot %0d dat/frm", bad_s),
                 int'({got_d[bad_s], got_f[bad_s]}), int'({exp_bits[bad_s], exp_frm(bad_s)}));
    end
  endtask

  task automatic start(input logic [2:0] f, input logic [1:0] w, input logic [1:0] r);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    exp_q.delete();
    cfg_fmt = f; cfg_wlen = w; cfg_rate = r;
    repeat (3) @(negedge clk);
    ur_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input logic [2:0] f, input logic [1:0] w, input logic [1:0] r);
    start(f, w, r);
    check(cfg_err == 1'b0, "R11", "legal config flag", int'(cfg_err), 0);
    fork
      driver(3);
      monitor(5);
    join
  endtask

  task automatic err_cfg(input logic [2:0] f, input logic [1:0] w, input logic [1:0] r);
    bit ok = 1'b1;
    start(f, w, r);
    smp_valid = 1'b1;
    repeat (600) begin
      @(negedge clk);
      if (!cfg_err || ser_dat || smp_ready || underrun) ok = 1'b0;
    end
    check(ok, "R11", "silent on illegal config", int'({cfg_err, ser_dat, smp_ready, underrun}), 8);
  endtask

  initial begin
    cfg_rate = 2'd0;
    repeat (3) @(negedge clk);
    check(!ser_dat && !frm_clk && !smp_ready && !underrun, "R9", "reset outputs",
          int'({ser_dat, frm_clk, smp_ready, underrun}), 0);
    run_cfg(3'd0, 2'd0, 2'd0);  // left-justified 16, 64 slots
    run_cfg(3'd1, 2'd2, 2'd0);  // right-justified 24, padding in front
    run_cfg(3'd1, 2'd0, 2'd1);  // right-justified 16 filling 32 slots
    run_cfg(3'd2, 2'd3, 2'd0);  // I2S 32 in 64: LSB spills to next frame
    run_cfg(3'd2, 2'd0, 2'd1);
    run_cfg(3'd3, 2'd0, 2'd1);  // delayed short sync, spill
    run_cfg(3'd3, 2'd1, 2'd0);
    run_cfg(3'd4, 2'd2, 2'd0);  // undelayed short sync
    run_cfg(3'd0, 2'd1, 2'd3);  // pass-through bit clock, 256 slots
    err_cfg(3'd1, 2'd3, 2'd0);  // R11 right-justified 32
    err_cfg(3'd0, 2'd1, 2'd2);  // R11 16 slots < 40
    err_cfg(3'd6, 2'd0, 2'd0);  // R11 unknown format
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule